// File: doc/BRIEF.md
# DRAM ZQ Calibration Scheduler

This block decides when a DRAM controller sends ZQ calibration commands and keeps the command path quiet until each one has settled. It raises a short calibration on a periodic timer and on a manual debug pulse. It raises a long calibration when the device leaves self-refresh, or when it leaves maximum power saving mode in DDR4 operation. Each command is offered to the command arbiter through a request/grant handshake. After the grant, the block holds `busy` high for a programmable quiet window, which is separate for long and short calibrations and is counted in controller (half-rate) clock cycles.

Two ranks are supported. If the ranks share one calibration resistor, the block calibrates rank 0 and then rank 1. The request for rank 1 is raised only after the quiet window of rank 0 has run out, so the two commands never overlap. If the resistor is not shared, one command covers both ranks and is followed by a single quiet window. Triggers that arrive while work is already pending or running are merged rather than queued. A pending long calibration also covers any short one.

The controller is one state machine with three states:
- `ST_IDLE` waits for pending work. The transition *dispatch* moves it to `ST_REQ` and picks long or short.
- `ST_REQ` holds the request. The transition *grant* moves it to `ST_WAIT` and loads the quiet counter.
- `ST_WAIT` runs the quiet window. When the window expires:
  - *advance* returns it to `ST_REQ` for the next rank in shared mode.
  - *finish* returns it to `ST_IDLE` after the last rank and restarts the periodic timer.

Top module: `zqc_scheduler`

## Requirements
- R1: After reset, `cmd_req` and `busy` are 0.
- R2: With `cfg_auto_off`=0 and `cfg_interval`=K>0, a short calibration request (`cmd_long`=0) rises about K*1024 cycles after the timer restarts, and not before. K=0 generates no periodic requests.
- R3: With `cfg_auto_off`=1, no periodic request is made. A pulse on `ev_dbg_short` still produces a short calibration request.
- R4: A pulse on `ev_srx_exit` produces a long calibration request (`cmd_long`=1) when `cfg_srx_off`=0. It produces no request when `cfg_srx_off`=1.
- R5: A pulse on `ev_mpsm_exit` produces a long calibration request only when `cfg_ddr4`=1 and `cfg_mpsm_off`=0. Otherwise it produces no request.
- R6: After the grant of a long calibration, `busy` is high for exactly `cfg_long_wait` cycles, with a minimum of 1.
- R7: After the grant of a short calibration, `busy` is high for exactly `cfg_short_wait` cycles, with a minimum of 1.
- R8: With `cfg_shared_res`=1, the block makes two requests in order:
  - The first has `cmd_rank`=2'b01. After its quiet window, the second has `cmd_rank`=2'b10.
  - The second request never rises while a quiet window is running.
  - `busy` stays high from the first grant until the second window ends.
- R9: With `cfg_shared_res`=0, a single request with `cmd_rank`=2'b11 is made, followed by one quiet window.
- R10: `cmd_req` stays high, with `cmd_long` and `cmd_rank` stable, until `cmd_gnt` is seen.
- R11: Repeated short triggers while work is pending or running are absorbed. A pending long calibration satisfies pending short triggers, so exactly one command is issued.
- R12: The periodic interval restarts when a calibration completes. The next periodic request comes about K*1024 cycles after `busy` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_auto_off | input | 1 | 1 turns off periodic short calibration |
| cfg_srx_off | input | 1 | 1 suppresses long calibration on self-refresh exit |
| cfg_mpsm_off | input | 1 | 1 suppresses long calibration on power-saving exit |
| cfg_ddr4 | input | 1 | DDR4 mode; enables the power-saving exit trigger |
| cfg_shared_res | input | 1 | Ranks share one calibration resistor |
| cfg_long_wait | input | 11 | Quiet cycles after a long calibration |
| cfg_short_wait | input | 10 | Quiet cycles after a short calibration |
| cfg_interval | input | 12 | Periodic interval in 1024-cycle units |
| ev_srx_exit | input | 1 | Self-refresh exit pulse |
| ev_mpsm_exit | input | 1 | Maximum power saving mode exit pulse |
| ev_dbg_short | input | 1 | Manual short calibration pulse |
| cmd_req | output | 1 | Calibration command request to the arbiter |
| cmd_long | output | 1 | 1 = long calibration, 0 = short |
| cmd_rank | output | 2 | Target ranks, one bit per rank |
| cmd_gnt | input | 1 | Arbiter grant |
| busy | output | 1 | Command path must hold NOP |

## Verification
The bench counts `busy` cycles exactly after each grant and checks that long and short windows use their own counts. A design that swapped the two counts, or that was off by one at the start or end of the window, would show a wrong count. In shared mode, the bench looks at the gap between the two rank commands. A design that overlapped the ranks would raise the second request while the first window was still running, or would drop `busy` in the gap. Merging is checked by sending several triggers before a grant and then watching for any extra request. A design that queued duplicates, or that issued a short calibration after a long one had covered it, would make a second request. The periodic timer is checked against a window around 2048 cycles, both after it is enabled and after a completion, which catches a design that never restarts the interval.

// File: rtl/zqc_pkg.sv
package zqc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_REQ,
        ST_WAIT
    } zqc_state_e;

    localparam int ZQC_NRANK = 2;
endpackage

// File: rtl/zqc_period_timer.sv
module zqc_period_timer #(
    parameter int IVL_W       = 12,
    parameter int UNIT_CYCLES = 1024
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             restart,
    input  logic [IVL_W-1:0] interval,
    output logic             tick
);
    localparam int PRE_W = (UNIT_CYCLES > 1) ? $clog2(UNIT_CYCLES) : 1;

    logic [PRE_W-1:0] pre;
    logic [IVL_W-1:0] units;
    logic             pre_wrap;
    logic             unit_last;

    assign pre_wrap  = (pre == PRE_W'(UNIT_CYCLES - 1));
    assign unit_last = (units == (interval - IVL_W'(1)));
    assign tick      = en && (interval != '0) && pre_wrap && unit_last;

    always_ff @(posedge clk) begin
        if (!rst_n || restart || !en || tick) begin
            pre   <= '0;
            units <= '0;
        end else if (pre_wrap) begin
            pre   <= '0;
            units <= units + IVL_W'(1);
        end else begin
            pre <= pre + PRE_W'(1);
        end
    end

    AST_TICK_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> !tick); // R3
    AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick); // R2
endmodule

// File: rtl/zqc_nop_counter.sv
module zqc_nop_counter #(
    parameter int W = 11
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expire,
    output logic         running
);
    logic [W-1:0] cnt;

    assign running = (cnt != '0);
    assign expire  = (cnt == W'(1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= (load_val == '0) ? W'(1) : load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - W'(1);
        end
    end

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !load) |=> (cnt == $past(cnt) - W'(1))); // R6
    AST_CNT_LOADED: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> running); // R7
endmodule

// File: rtl/zqc_scheduler.sv
module zqc_scheduler
    import zqc_pkg::*;
#(
    parameter int LONG_W      = 11,
    parameter int SHORT_W     = 10,
    parameter int IVL_W       = 12,
    parameter int UNIT_CYCLES = 1024,
    parameter int NRANK       = ZQC_NRANK
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_auto_off,
    input  logic               cfg_srx_off,
    input  logic               cfg_mpsm_off,
    input  logic               cfg_ddr4,
    input  logic               cfg_shared_res,
    input  logic [LONG_W-1:0]  cfg_long_wait,
    input  logic [SHORT_W-1:0] cfg_short_wait,
    input  logic [IVL_W-1:0]   cfg_interval,
    input  logic               ev_srx_exit,
    input  logic               ev_mpsm_exit,
    input  logic               ev_dbg_short,
    output logic               cmd_req,
    output logic               cmd_long,
    output logic [NRANK-1:0]   cmd_rank,
    input  logic               cmd_gnt,
    output logic               busy
);
    localparam int CNT_W  = (LONG_W > SHORT_W) ? LONG_W : SHORT_W;
    localparam int RIDX_W = (NRANK > 1) ? $clog2(NRANK) : 1;

    zqc_state_e        state, state_nx;
    logic              pend_long, pend_short;
    logic              cur_long, shared_q;
    logic [RIDX_W-1:0] ridx;
    logic [NRANK-1:0]  rank_vec;
    logic              long_ev, short_ev, tick;
    logic              dispatch, grant, last_rank, finish, advance;
    logic              cnt_expire, cnt_running;
    logic [CNT_W-1:0]  wait_val;

    // Trigger qualification
    assign long_ev  = (ev_srx_exit & ~cfg_srx_off)
                    | (ev_mpsm_exit & cfg_ddr4 & ~cfg_mpsm_off);
    assign short_ev = ev_dbg_short | tick;

    assign dispatch  = (state == ST_IDLE) && (pend_long || pend_short);
    assign grant     = (state == ST_REQ) && cmd_gnt;
    assign last_rank = !shared_q || (ridx == RIDX_W'(NRANK - 1));
    assign finish    = (state == ST_WAIT) && cnt_expire && last_rank;
    assign advance   = (state == ST_WAIT) && cnt_expire && !last_rank;
    assign wait_val  = cur_long ? CNT_W'(cfg_long_wait) : CNT_W'(cfg_short_wait);

    zqc_period_timer #(
        .IVL_W       (IVL_W),
        .UNIT_CYCLES (UNIT_CYCLES)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (~cfg_auto_off),
        .restart  (finish),
        .interval (cfg_interval),
        .tick     (tick)
    );

    zqc_nop_counter #(
        .W (CNT_W)
    ) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (grant),
        .load_val (wait_val),
        .expire   (cnt_expire),
        .running  (cnt_running)
    );

    // Pending work, merged
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_long  <= 1'b0;
            pend_short <= 1'b0;
        end else if (dispatch) begin
            pend_long  <= long_ev;
            pend_short <= 1'b0;
        end else begin
            pend_long  <= pend_long | long_ev;
            pend_short <= pend_short
                        | (short_ev & (state == ST_IDLE) & ~pend_long);
        end
    end

    // Current command context
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_long <= 1'b0;
            shared_q <= 1'b0;
            ridx     <= '0;
        end else if (dispatch) begin
            cur_long <= pend_long;
            shared_q <= cfg_shared_res;
            ridx     <= '0;
        end else if (advance) begin
            ridx <= ridx + RIDX_W'(1);
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (dispatch) state_nx = ST_REQ;
            ST_REQ:  if (grant)    state_nx = ST_WAIT;
            ST_WAIT: begin
                if (advance)     state_nx = ST_REQ;
                else if (finish) state_nx = ST_IDLE;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    for (genvar r = 0; r < NRANK; r++) begin : g_rank
        assign rank_vec[r] = shared_q ? (ridx == RIDX_W'(r)) : 1'b1;
    end

    // Outputs
    always_comb begin
        cmd_req  = (state == ST_REQ);
        cmd_long = cur_long;
        cmd_rank = rank_vec;
        busy     = (state == ST_WAIT) || ((state == ST_REQ) && (ridx != '0));
    end

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_req && !cmd_gnt) |=> cmd_req); // R10
    AST_REQ_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_req && !cmd_gnt) |=> ($stable(cmd_long) && $stable(cmd_rank))); // R10
    AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_running |-> !cmd_req); // R8
    AST_ONE_RANK: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_req && shared_q) |-> ($countones(cmd_rank) == 1)); // R8
    AST_BUSY_AFTER_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_req && cmd_gnt) |=> busy); // R6
endmodule

// File: tb/zqc_scheduler_bench.sv
module zqc_scheduler_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_auto_off = 1'b1;
    logic        cfg_srx_off = 1'b0;
    logic        cfg_mpsm_off = 1'b0;
    logic        cfg_ddr4 = 1'b0;
    logic        cfg_shared_res = 1'b0;
    logic [10:0] cfg_long_wait = 11'd20;
    logic [9:0]  cfg_short_wait = 10'd12;
    logic [11:0] cfg_interval = 12'd2;
    logic        ev_srx_exit = 1'b0;
    logic        ev_mpsm_exit = 1'b0;
    logic        ev_dbg_short = 1'b0;
    logic        cmd_req, cmd_long, cmd_gnt = 1'b0, busy;
    logic [1:0]  cmd_rank;

    int n_tests = 0;
    int n_fail  = 0;

    always #5 clk = ~clk;

    zqc_scheduler u_zqc_scheduler (
        .clk(clk), .rst_n(rst_n),
        .cfg_auto_off(cfg_auto_off), .cfg_srx_off(cfg_srx_off),
        .cfg_mpsm_off(cfg_mpsm_off), .cfg_ddr4(cfg_ddr4),
        .cfg_shared_res(cfg_shared_res), .cfg_long_wait(cfg_long_wait),
        .cfg_short_wait(cfg_short_wait), .cfg_interval(cfg_interval),
        .ev_srx_exit(ev_srx_exit), .ev_mpsm_exit(ev_mpsm_exit),
        .ev_dbg_short(ev_dbg_short), .cmd_req(cmd_req), .cmd_long(cmd_long),
        .cmd_rank(cmd_rank), .cmd_gnt(cmd_gnt), .busy(busy)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic pulse(input int which);
        @(negedge clk);
        if (which == 0) ev_srx_exit = 1'b1;
        if (which == 1) ev_mpsm_exit = 1'b1;
        if (which == 2) ev_dbg_short = 1'b1;
        @(negedge clk);
        ev_srx_exit = 1'b0; ev_mpsm_exit = 1'b0; ev_dbg_short = 1'b0;
    endtask

    task automatic quiet(input int cycles, input string req);
        int seen = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (cmd_req) seen++;
        end
        chk(seen == 0, req, seen, 0);
    endtask

    // Wait for a request, check it, grant, count quiet cycles
    task automatic serve(input bit exp_long, input logic [1:0] exp_rank,
                         input int exp_wait, input string req);
        int t = 0;
        int n = 0;
        while (!cmd_req && t < 200) begin @(negedge clk); t++; end
        chk(cmd_req == 1'b1, req, cmd_req, 1);
        chk(cmd_long == exp_long, req, cmd_long, exp_long);
        chk(cmd_rank == exp_rank, req, cmd_rank, exp_rank);
        cmd_gnt = 1'b1;
        @(negedge clk);
        cmd_gnt = 1'b0;
        while (busy && !cmd_req && n < 5000) begin n++; @(negedge clk); end
        chk(n == exp_wait, req, n, exp_wait);
    endtask

    task automatic t_reset;
        chk(cmd_req == 1'b0, "R1", cmd_req, 0);
        chk(busy == 1'b0, "R1", busy, 0);
    endtask

    task automatic t_srx;
        pulse(0);
        repeat (3) @(negedge clk);
        chk(cmd_req == 1'b1, "R10", cmd_req, 1);   // held without grant
        serve(1'b1, 2'b11, 20, "R4/R6/R9");
        chk(busy == 1'b0, "R9", busy, 0);
        cfg_srx_off = 1'b1;
        pulse(0);
        quiet(30, "R4");
        cfg_srx_off = 1'b0;
    endtask

    task automatic t_dbg_short;
        pulse(2);
        serve(1'b0, 2'b11, 12, "R7");
        cfg_short_wait = 10'd0;                    // minimum of one cycle
        pulse(2);
        serve(1'b0, 2'b11, 1, "R7");
        cfg_short_wait = 10'd12;
    endtask

    task automatic t_mpsm;
        cfg_ddr4 = 1'b0;
        pulse(1);
        quiet(30, "R5");
        cfg_ddr4 = 1'b1;
        pulse(1);
        serve(1'b1, 2'b11, 20, "R5");
        cfg_mpsm_off = 1'b1;
        pulse(1);
        quiet(30, "R5");
        cfg_mpsm_off = 1'b0;
        cfg_ddr4 = 1'b0;
    endtask

    task automatic t_shared;
        int gap_bad = 0;
        cfg_shared_res = 1'b1;
        pulse(2);
        serve(1'b0, 2'b01, 12, "R8");
        for (int i = 0; i < 3; i++) begin
            if (!busy || !cmd_req) gap_bad++;
            @(negedge clk);
        end
        chk(gap_bad == 0, "R8", gap_bad, 0);
        serve(1'b0, 2'b10, 12, "R8");
        chk(busy == 1'b0, "R8", busy, 0);
        cfg_shared_res = 1'b0;
    endtask

    task automatic t_merge;
        pulse(0);
        pulse(2);
        pulse(2);
        serve(1'b1, 2'b11, 20, "R11");
        quiet(40, "R11");
        pulse(2);
        pulse(2);
        serve(1'b0, 2'b11, 12, "R11");
        quiet(40, "R11");
    endtask

    task automatic t_auto_off;
        quiet(3000, "R3");
        pulse(2);
        serve(1'b0, 2'b11, 12, "R3");
    endtask

    task automatic t_periodic;
        int k = 0;
        @(negedge clk);
        cfg_auto_off = 1'b0;
        while (!cmd_req && k < 3000) begin @(negedge clk); k++; end
        chk(k >= 2040 && k <= 2060, "R2", k, 2048);
        serve(1'b0, 2'b11, 12, "R2");
        k = 0;
        while (!cmd_req && k < 3000) begin @(negedge clk); k++; end
        chk(k >= 2040 && k <= 2060, "R12", k, 2048);
        serve(1'b0, 2'b11, 12, "R12");
        cfg_interval = 12'd0;
        quiet(2500, "R2");
        cfg_auto_off = 1'b1;
        cfg_interval = 12'd2;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_srx();
        t_dbg_short();
        t_mpsm();
        t_shared();
        t_merge();
        t_auto_off();
        t_periodic();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule